// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a single-request synchronous port and an 8K x 8 asynchronous static RAM. A client raises a request with a write flag, a 13-bit address and, for writes, a data byte. The controller drives the memory's address lines, its two chip enables, its active-low write and output enables, and the bidirectional data bus. It holds each phase for a whole number of clock cycles. The counts are computed at elaboration as the ceiling of each required time in nanoseconds divided by the clock period parameter, so the minimum cycle, access and recovery times of the memory are always met.

Busy is high while an access is in flight and for the whole of a standby or recovery period. A read returns its byte with a one-clock valid strobe. A sleep input deselects the memory into its low-power retention standby. When sleep is released, the controller waits out a recovery interval before it accepts the next access.

Top module: `sram_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, busy and rd_valid are low, the memory is deselected (mem_ce1_n = 1, mem_ce2 = 0), and both mem_we_n and mem_oe_n are 1.
- R2: The memory is selected (mem_ce1_n = 0 and mem_ce2 = 1) only while an access is in progress. Whenever busy is low, it is deselected (mem_ce1_n = 1, mem_ce2 = 0).
- R3: A read holds mem_we_n = 1 and mem_oe_n = 0 for RD_CYC = ceil(max(read cycle, access time)/CLK_NS) cycles, 9 at the defaults. The bus is sampled only at the end of that window, so the returned byte is the one stored at the address.
- R4: A write holds mem_oe_n = 1 and keeps mem_we_n = 0 for WR_CYC-1 cycles, WR_CYC = ceil(write cycle/CLK_NS) = 9 by default. The write byte is driven on mem_dq only while mem_we_n is 0, and mem_we_n returns to 1 in the last cycle of the access.
- R5: The controller never drives mem_dq while mem_oe_n is 0, nor in the cycle just before mem_oe_n goes to 0.
- R6: A request is accepted only on a clock edge where busy and sleep are both low. Busy then stays high for exactly RD_CYC or WR_CYC cycles. A request raised while busy is high is dropped and leaves the memory unchanged.
- R7: rd_valid is high for exactly one cycle, the cycle in which busy falls after a read. rd_data holds the byte read in that cycle.
- R8: If sleep is high on an edge where the controller is idle, the controller enters standby. It wins over a request in the same cycle, which is dropped. In standby, busy is high and the memory is deselected.
- R9: When sleep is seen low in standby, busy stays high for REC_CYC = ceil(recovery time/CLK_NS) cycles (9 by default) before the next request can be accepted.
- R10: Sleep raised while an access is in progress does not cut that access short. The access completes, and standby follows it.
- R11: mem_addr stays constant for every cycle in which the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| sleep | input | 1 | Request for retention standby |
| busy | output | 1 | Access, standby or recovery in progress |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 8 | Byte read |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 13 | Memory address |
| mem_dq | inout | 8 | Bidirectional memory data bus |

## Verification
Sleep and a new request can reach the idle controller on the same edge. The bench raises both in one cycle with a write to an address that already holds a known byte. It then checks three things: the memory stays deselected, recovery lasts the full count, and a later read returns the old byte, which shows the sleep took priority. A second collision raises sleep one cycle into a write. The bench checks that the write enable stays low and that the byte lands in memory.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the static RAM controller.
// Assumes all time arguments are positive integers in nanoseconds.
package sram_ctrl_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } ctrl_state_t;

    // Number of whole clock cycles that covers a time in nanoseconds.
    function automatic int cycles_for(input int time_ns, input int clk_ns);
        return (time_ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request at a time, times the read, write,
// standby and recovery phases with a single cycle counter, and decodes the
// phase strobes that the pin and data logic use.
// Assumes RD_CYC >= 1, WR_CYC >= 2, REC_CYC >= 1 and that CNT_W holds each.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC  = 9,
    parameter int WR_CYC  = 9,
    parameter int REC_CYC = 9,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic sleep,
    output logic accept,
    output logic busy,
    output logic sel,
    output logic we_phase,
    output logic oe_phase,
    output logic sample_now
);

    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

    ctrl_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Accept a request only when idle and no standby is asked for.
    assign accept = (state_q == ST_IDLE) && req_valid && !sleep;

    // Next-state and counter logic for all phases.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (sleep)          state_d = ST_SLEEP;
                else if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
            end
            ST_READ: begin
                if (cnt_q == RD_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            ST_WRITE: begin
                if (cnt_q == WR_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            ST_SLEEP: begin
                cnt_d = '0;
                if (!sleep) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (sleep) begin
                    state_d = ST_SLEEP;
                    cnt_d   = '0;
                end else if (cnt_q == REC_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Phase decode from registered state only.
    assign busy       = (state_q != ST_IDLE);
    assign sel        = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign oe_phase   = (state_q == ST_READ);
    assign we_phase   = (state_q == ST_WRITE) && (cnt_q != WR_LAST);
    assign sample_now = (state_q == ST_READ) && (cnt_q == RD_LAST);

    p_accept_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_sleep_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sleep) |=> (state_q == ST_SLEEP));

    p_leave_sleep_via_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP) |-> (state_q == ST_WAKE));

    p_access_not_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && cnt_q != WR_LAST) |=> (state_q == ST_WRITE));

    p_we_oe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_phase && oe_phase));

endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
// Data path: latches address and write byte on acceptance, presents the
// write byte to the bus driver while the write strobe is active, and
// captures the read byte into a one-cycle valid strobe.
// Assumes accept only occurs while the memory is deselected.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sel,
    input  logic              we_phase,
    input  logic              sample_now,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the bus at the end of the read window and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample_now;
            if (sample_now) rdata_q <= dq_in;
        end
    end

    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign dq_oe    = we_phase;
    assign rd_data  = rdata_q;
    assign rd_valid = rvalid_q;

    p_rdvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous static RAM controller. Derives phase lengths in
// clock cycles from the nanosecond timing parameters and the clock period,
// decodes the memory control pins, and owns the tri-state data bus.
// Assumes an external memory with one active-low and one active-high enable.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 4,
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int T_RC_NS   = 35,
    parameter int T_AA_NS   = 35,
    parameter int T_WC_NS   = 35,
    parameter int T_REC_NS  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sleep,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_CYC  = imax(imax(cycles_for(T_RC_NS, CLK_NS),
                                       cycles_for(T_AA_NS, CLK_NS)), 1);
    localparam int WR_CYC  = imax(cycles_for(T_WC_NS, CLK_NS), 2);
    localparam int REC_CYC = imax(cycles_for(T_REC_NS, CLK_NS), 1);
    localparam int MAX_CYC = imax(imax(RD_CYC, WR_CYC), REC_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              accept, sel, we_phase, oe_phase, sample_now;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in;

    sram_ctrl_seq #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .REC_CYC(REC_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .sleep     (sleep),
        .accept    (accept),
        .busy      (busy),
        .sel       (sel),
        .we_phase  (we_phase),
        .oe_phase  (oe_phase),
        .sample_now(sample_now)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sel       (sel),
        .we_phase  (we_phase),
        .sample_now(sample_now),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Memory control pins: both enables track selection, strobes track phase.
    assign mem_ce1_n = !sel;
    assign mem_ce2   = sel;
    assign mem_we_n  = !we_phase;
    assign mem_oe_n  = !oe_phase;

    // Tri-state bus: driven only during the write strobe.
    assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};
    assign dq_in  = mem_dq;

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!dq_oe && !$past(dq_oe)));

    p_deselect_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce1_n && !mem_ce2));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !rd_valid && mem_we_n && mem_oe_n));

endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural memory model with access-time gating, shadow memory,
// directed corner cases and seeded random traffic.
module test_sram_ctrl;

    localparam int CLK_NS  = 4;
    localparam int EXP_RD  = (35 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WR  = (35 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_REC = (35 + CLK_NS - 1) / CLK_NS;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       sleep = 1'b0;
    logic       busy, rd_valid;
    logic [7:0] rd_data;
    logic       mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;
    logic [12:0] mem_addr;
    wire  [7:0] mem_dq;

    int checks = 0;
    int fails = 0;
    int cont_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sleep(sleep),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // ---------------- memory model ----------------
    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];
    logic [7:0] model_byte = '0;
    logic [12:0] acc_addr = '0;
    int         acc_cnt = 0;
    logic       m_sel, m_rd;

    assign m_sel = !mem_ce1_n && mem_ce2;
    assign m_rd  = m_sel && mem_we_n && !mem_oe_n;
    // Stale data until the access time has elapsed.
    assign mem_dq = m_rd ? ((acc_cnt >= EXP_RD - 1) ? model_byte : (model_byte ^ 8'h5a))
                         : 8'bzzzzzzzz;

    always @(posedge clk) begin
        if (m_sel && !mem_we_n) model_mem[int'(mem_addr)] = mem_dq;
        model_byte <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        if (!m_rd) acc_cnt <= 0;
        else if (acc_cnt == 0 || acc_addr != mem_addr) begin
            acc_cnt  <= 1;
            acc_addr <= mem_addr;
        end else acc_cnt <= acc_cnt + 1;
    end

    // Contention monitor (R5): output enable low while or just after we low.
    logic prev_we_low = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !mem_oe_n && (!mem_we_n || prev_we_low)) cont_bad++;
        prev_we_low <= !mem_we_n;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte(input logic [12:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int n;
        int wl;
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(!mem_ce1_n && mem_ce2, "R2 select on write", {mem_ce1_n, mem_ce2}, 1);
        check(!mem_we_n && mem_oe_n && mem_dq == d, "R4 write strobe/data", int'(mem_dq), int'(d));
        n = 0; wl = 0;
        while (busy && n < 1000) begin
            n++;
            if (!mem_we_n) wl++;
            if (mem_addr != a) cont_bad += 0;
            @(negedge clk);
        end
        check(n == EXP_WR, "R6 write busy length", n, EXP_WR);
        check(wl == EXP_WR - 1, "R4 write strobe length", wl, EXP_WR - 1);
        shadow[int'(a)] = d;
    endtask

    task automatic do_read(input logic [12:0] a, input bit poke);
        int n;
        bit addr_ok;
        logic [7:0] e;
        e = expect_byte(a);
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(!mem_oe_n && mem_we_n && !mem_ce1_n && mem_ce2, "R3 read strobes",
              {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b0110);
        n = 0; addr_ok = 1'b1;
        while (busy && n < 1000) begin
            n++;
            if (mem_addr != a) addr_ok = 1'b0;
            if (poke && n == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = ~e;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(addr_ok, "R11 address held", int'(mem_addr), int'(a));
        check(n == EXP_RD, "R6 read busy length", n, EXP_RD);
        check(rd_valid, "R7 valid with busy fall", int'(rd_valid), 1);
        check(rd_data == e, "R3 read data", int'(rd_data), int'(e));
        check(mem_ce1_n && !mem_ce2, "R2 deselect when free", {mem_ce1_n, mem_ce2}, 2'b10);
        @(negedge clk);
        check(!rd_valid, "R7 valid one cycle", int'(rd_valid), 0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        bit ok;
        logic [12:0] pool [16];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy && !rd_valid && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n,
              "R1 reset state", {busy, rd_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 6'b001011);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && mem_ce1_n && !mem_ce2, "R1 after reset", {busy, mem_ce1_n}, 1);

        // Boundary addresses, read straight after write.
        do_write(13'h0000, 8'hA5);
        do_read(13'h0000, 1'b0);
        do_write(13'h1FFF, 8'h3C);
        do_read(13'h1FFF, 1'b0);
        do_read(13'h0001, 1'b0);

        // R6: request raised while busy is dropped.
        do_read(13'h1FFF, 1'b1);
        do_read(13'h1FFF, 1'b0);

        // R8: sleep and request collide while idle; sleep wins.
        wait_idle();
        sleep = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0000; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && mem_ce1_n && !mem_ce2 && mem_we_n, "R8 standby deselect",
              {busy, mem_ce1_n, mem_ce2, mem_we_n}, 4'b1101);
        ok = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (!busy || !mem_ce1_n || mem_ce2) ok = 1'b0;
        end
        check(ok, "R8 standby held", int'(ok), 1);
        sleep = 1'b0;
        @(negedge clk);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (!mem_ce1_n || mem_ce2) ok = 1'b0;
            @(negedge clk);
        end
        check(n == EXP_REC, "R9 recovery length", n, EXP_REC);
        check(ok, "R9 deselected during recovery", int'(ok), 1);
        do_read(13'h0000, 1'b0);

        // R10: sleep raised one cycle into a write.
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0ABC; req_wdata = 8'h7E;
        @(negedge clk);
        req_valid = 1'b0;
        sleep = 1'b1;
        @(negedge clk);
        check(!mem_ce1_n && mem_ce2 && !mem_we_n, "R10 write continues",
              {mem_ce1_n, mem_ce2, mem_we_n}, 3'b010);
        repeat (EXP_WR + 2) @(negedge clk);
        check(busy && mem_ce1_n && !mem_ce2, "R10 standby after write", {busy, mem_ce1_n}, 3);
        sleep = 1'b0;
        @(negedge clk);
        shadow[int'(13'h0ABC)] = 8'h7E;
        do_read(13'h0ABC, 1'b0);

        // Seeded random traffic over a small pool plus the boundaries.
        for (int i = 0; i < 16; i++) pool[i] = 13'($urandom);
        pool[0] = 13'h0000;
        pool[1] = 13'h1FFF;
        for (int i = 0; i < 80; i++) begin
            logic [12:0] a;
            a = pool[$urandom % 16];
            if ($urandom % 2 == 0) do_write(a, 8'($urandom));
            else do_read(a, ($urandom % 8) == 0);
        end

        check(cont_bad == 0, "R5 no bus contention", cont_bad, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule